// File: doc/BRIEF.md
# Master/Checker Redundancy Comparator

This block sits between a processor core and its shared pins so that two identical devices can run in lockstep and check each other. A strap input is captured while reset is held and fixes the role of the device until the next reset. In master role the core's output values and enables pass straight to the pins. In checker role every pin driver in the compared group is switched off. The values that the master drives onto the shared pins are then read back and compared, every clock, against what the local core predicts.

A comparison is made only on bits whose predicted enable is set in that cycle. Any disagreement sets a sticky internal-error output one clock later. Only a reset clears it. The error output and the test-data-out output stay driven in both roles, so a checker can still report.

Top module: `redund_cmp`

## Requirements
- R1: The role is taken from `role_strap_i` on every rising clock edge where `rst` is high. After reset the role is the strap value at the last such edge: 1 selects master, 0 selects checker.
- R2: While `rst` is low, changes on `role_strap_i` do not change the role. The pin enables keep the behaviour of the role that was latched.
- R3: In master role, `pad_out_o` equals `core_out_i` and `pad_oe_o` equals `core_oe_i` in the same cycle.
- R4: In checker role, every bit of `pad_oe_o` is 0 whatever `core_oe_i` holds.
- R5: In checker role, with `rst` low, a cycle in which a bit has `core_oe_i` = 1 and `pad_in_i` differing from `core_out_i` makes `ierr_o` 1 from the next clock edge.
- R6: A bit with `core_oe_i` = 0 is never compared. Its `pad_in_i` value has no effect on `ierr_o`.
- R7: `ierr_o` is 0 after reset. Once set, it stays 1 until `rst` is asserted.
- R8: In master role, `ierr_o` stays 0 whatever `pad_in_i` holds.
- R9: In both roles, `ierr_oe_o` is 1, and `tdo_o`/`tdo_oe_o` follow `core_tdo_i`/`core_tdo_oe_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the strap capture window |
| role_strap_i | input | 1 | Role strap: 1 master, 0 checker |
| core_out_i | input | W | Output values predicted by the core |
| core_oe_i | input | W | Output enables predicted by the core |
| pad_in_i | input | W | Values read back from the shared pins |
| core_tdo_i | input | 1 | Test-data-out value from the core |
| core_tdo_oe_i | input | 1 | Test-data-out enable from the core |
| pad_out_o | output | W | Values driven to the pins |
| pad_oe_o | output | W | Pin output enables |
| tdo_o | output | 1 | Test-data-out pin value |
| tdo_oe_o | output | 1 | Test-data-out pin enable |
| ierr_o | output | 1 | Sticky internal-error flag |
| ierr_oe_o | output | 1 | Internal-error pin enable, always on |

## Verification
The hardest case to reach from the ports is a strap that changes within one reset window, or right after it. This must show that only the last reset edge counts and that later toggles are ignored. The bench holds reset for two edges with different strap values and then flips the strap at once when reset is released. It checks the enables of the role that resulted. Masked mismatches are driven on disabled bits and must stay silent. Stickiness is shown by returning to matching inputs for several cycles after an error.

// File: rtl/redund_pkg.sv
package redund_pkg;

    typedef enum logic {
        ROLE_CHECKER = 1'b0,
        ROLE_MASTER  = 1'b1
    } role_e;

    function automatic role_e decode_strap(input logic strap);
        return strap ? ROLE_MASTER : ROLE_CHECKER;
    endfunction

endpackage

// File: rtl/redund_role_latch.sv
module redund_role_latch
    import redund_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strap_i,
    output role_e role_o
);
    // Loaded only while reset is held; otherwise the role never moves.
    always_ff @(posedge clk) begin
        if (rst) begin
            role_o <= decode_strap(strap_i);
        end
    end
endmodule

// File: rtl/redund_pad_gate.sv
module redund_pad_gate
    import redund_pkg::*;
#(
    parameter int W = 8
) (
    input  role_e          role_i,
    input  logic [W-1:0]   core_out_i,
    input  logic [W-1:0]   core_oe_i,
    output logic [W-1:0]   pad_out_o,
    output logic [W-1:0]   pad_oe_o
);
    logic drive_en;
    assign drive_en = (role_i == ROLE_MASTER);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pad_out_o[i] = core_out_i[i];
        assign pad_oe_o[i]  = drive_en & core_oe_i[i];
    end
endmodule

// File: rtl/redund_compare.sv
module redund_compare
    import redund_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  role_e          role_i,
    input  logic [W-1:0]   core_out_i,
    input  logic [W-1:0]   core_oe_i,
    input  logic [W-1:0]   pad_in_i,
    output logic           err_o
);
    logic [W-1:0] diff;
    logic         hit;

    // Only enabled bits take part in the comparison.
    for (genvar i = 0; i < W; i++) begin : g_cmp
        assign diff[i] = core_oe_i[i] & (core_out_i[i] ^ pad_in_i[i]);
    end

    assign hit = (role_i == ROLE_CHECKER) && (|diff);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o <= 1'b0;
        end else begin
            err_o <= err_o | hit;
        end
    end
endmodule

// File: rtl/redund_cmp.sv
module redund_cmp
    import redund_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          role_strap_i,
    input  logic [W-1:0]  core_out_i,
    input  logic [W-1:0]  core_oe_i,
    input  logic [W-1:0]  pad_in_i,
    input  logic          core_tdo_i,
    input  logic          core_tdo_oe_i,
    output logic [W-1:0]  pad_out_o,
    output logic [W-1:0]  pad_oe_o,
    output logic          tdo_o,
    output logic          tdo_oe_o,
    output logic          ierr_o,
    output logic          ierr_oe_o
);
    role_e role;

    redund_role_latch u_role (
        .clk     (clk),
        .rst     (rst),
        .strap_i (role_strap_i),
        .role_o  (role)
    );

    redund_pad_gate #(.W(W)) u_gate (
        .role_i     (role),
        .core_out_i (core_out_i),
        .core_oe_i  (core_oe_i),
        .pad_out_o  (pad_out_o),
        .pad_oe_o   (pad_oe_o)
    );

    redund_compare #(.W(W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .role_i     (role),
        .core_out_i (core_out_i),
        .core_oe_i  (core_oe_i),
        .pad_in_i   (pad_in_i),
        .err_o      (ierr_o)
    );

    // The reporting pins stay live in both roles.
    assign tdo_o     = core_tdo_i;
    assign tdo_oe_o  = core_tdo_oe_i;
    assign ierr_oe_o = 1'b1;
endmodule

// File: rtl/redund_cmp_sva.sv
module redund_cmp_sva #(
    parameter int W = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          role_strap_i,
    input logic          role_q,
    input logic [W-1:0]  core_out_i,
    input logic [W-1:0]  core_oe_i,
    input logic [W-1:0]  pad_in_i,
    input logic [W-1:0]  pad_oe_o,
    input logic          ierr_o,
    input logic          ierr_oe_o
);
    logic mism;
    assign mism = |((core_out_i ^ pad_in_i) & core_oe_i);

    assert_strap_capture_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (role_q == $past(role_strap_i)));

    assert_role_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(role_q));

    assert_master_oe_R3: assert property (@(posedge clk) disable iff (rst)
        role_q |-> (pad_oe_o == core_oe_i));

    assert_checker_float_R4: assert property (@(posedge clk) disable iff (rst)
        !role_q |-> (pad_oe_o == '0));

    assert_mismatch_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (!role_q && mism) |=> ierr_o);

    assert_only_enabled_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ierr_o) |-> ($past(mism) && !$past(role_q)));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ierr_o |=> ierr_o);

    assert_master_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        role_q |-> !ierr_o);

    assert_ierr_driven_R9: assert property (@(posedge clk) disable iff (rst)
        ierr_oe_o);
endmodule

bind redund_cmp redund_cmp_sva #(.W(W)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .role_strap_i (role_strap_i),
    .role_q       (role),
    .core_out_i   (core_out_i),
    .core_oe_i    (core_oe_i),
    .pad_in_i     (pad_in_i),
    .pad_oe_o     (pad_oe_o),
    .ierr_o       (ierr_o),
    .ierr_oe_o    (ierr_oe_o)
);

// File: tb/redund_cmp_tb.sv
module redund_cmp_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         role_strap_i = 1'b0;
    logic [W-1:0] core_out_i = '0, core_oe_i = '0, pad_in_i = '0;
    logic         core_tdo_i = 1'b0, core_tdo_oe_i = 1'b0;
    logic [W-1:0] pad_out_o, pad_oe_o;
    logic         tdo_o, tdo_oe_o, ierr_o, ierr_oe_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    redund_cmp #(.W(W)) u_dut (.*);

    typedef struct packed {
        logic         strap;
        logic [W-1:0] out;
        logic [W-1:0] oe;
        logic [W-1:0] pad;
        logic         err;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'hA5, 8'hFF, 8'h00, 1'b0},  // master ignores pins (R8)
        '{1'b0, 8'hA5, 8'hFF, 8'hA5, 1'b0},  // checker, all match
        '{1'b0, 8'hA5, 8'hFF, 8'hA4, 1'b1},  // bit0 mismatch (R5)
        '{1'b0, 8'hA5, 8'h0F, 8'h55, 1'b0},  // mismatch only on disabled bits (R6)
        '{1'b0, 8'hA5, 8'h80, 8'h25, 1'b1},  // msb mismatch, only msb enabled (R5)
        '{1'b0, 8'h00, 8'h00, 8'hFF, 1'b0},  // nothing enabled (R6)
        '{1'b1, 8'h3C, 8'h0F, 8'hC3, 1'b0}   // master pass-through (R3)
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Reset with strap value s; on release the strap is flipped to show it is ignored.
    task automatic do_reset(input logic s);
        @(negedge clk);
        rst = 1'b1; role_strap_i = s;
        core_oe_i = '0; core_out_i = '0; pad_in_i = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0; role_strap_i = ~s;
    endtask

    initial begin
        // Vector table
        for (int v = 0; v < NV; v++) begin
            do_reset(VECS[v].strap);
            core_out_i = VECS[v].out; core_oe_i = VECS[v].oe; pad_in_i = VECS[v].pad;
            #1;
            chk("R7 ierr clear after reset", {31'd0, ierr_o}, 32'd0);
            chk(VECS[v].strap ? "R3 master oe" : "R4 checker oe",
                {24'd0, pad_oe_o}, VECS[v].strap ? {24'd0, VECS[v].oe} : 32'd0);
            if (VECS[v].strap) chk("R3 master out", {24'd0, pad_out_o}, {24'd0, VECS[v].out});
            @(negedge clk);
            chk(VECS[v].strap ? "R8 master ierr" : "R5/R6 ierr",
                {31'd0, ierr_o}, {31'd0, VECS[v].err});
        end

        // R1: only the last reset edge counts
        @(negedge clk);
        rst = 1'b1; role_strap_i = 1'b0;
        @(negedge clk);
        role_strap_i = 1'b1;
        @(negedge clk);
        rst = 1'b0; role_strap_i = 1'b0; core_oe_i = 8'hF0;
        #1;
        chk("R1 last-edge strap gives master", {24'd0, pad_oe_o}, 32'hF0);

        // R2: strap toggles outside reset are ignored (checker role)
        do_reset(1'b0);
        core_oe_i = 8'hFF; core_out_i = 8'h5A; pad_in_i = 8'h5A;
        for (int k = 0; k < 4; k++) begin
            role_strap_i = k[0];
            @(negedge clk);
        end
        chk("R2 strap ignored after reset", {24'd0, pad_oe_o}, 32'd0);

        // R9: reporting pins in checker role
        core_tdo_i = 1'b1; core_tdo_oe_i = 1'b1;
        #1;
        chk("R9 tdo value", {31'd0, tdo_o}, 32'd1);
        chk("R9 tdo enable", {31'd0, tdo_oe_o}, 32'd1);
        chk("R9 ierr enable", {31'd0, ierr_oe_o}, 32'd1);

        // R7: error is sticky across clean cycles, cleared by reset
        pad_in_i = 8'h5B;
        @(negedge clk);
        chk("R5 error raised", {31'd0, ierr_o}, 32'd1);
        pad_in_i = 8'h5A;
        repeat (5) @(negedge clk);
        chk("R7 error sticky", {31'd0, ierr_o}, 32'd1);
        do_reset(1'b1);
        #1;
        chk("R7 error cleared by reset", {31'd0, ierr_o}, 32'd0);

        // R9 in master role
        core_tdo_i = 1'b0; core_tdo_oe_i = 1'b1;
        #1;
        chk("R9 master tdo", {30'd0, tdo_o, tdo_oe_o}, 32'd1);
        chk("R9 master ierr enable", {31'd0, ierr_oe_o}, 32'd1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule